// File: doc/BRIEF.md
# Cache control command unit

This block is the command and status front end of a small two-way, sixteen-set data cache. Software loads a line address into an address register. It then writes a four-bit command code to start one of several operations: enable, disable, load-and-lock, unlock-line, unlock-all, invalidate-all or flush. The block keeps the valid, lock and tag state of every line. It also keeps an enable bit, a busy bit and two sticky error bits. Software reads all of these through a four-bit status port, and reading that port clears the error bits.

Most commands finish in the cycle the command is written. Load-and-lock on a miss, flush on a hit, and CPU misses on an enabled cache start a memory transfer through a request/acknowledge handshake. While such a transfer runs, the unit is busy and holds the CPU stall high. A failed memory reply during lock or flush is a fatal error. It sets the first error bit, turns the cache off and pulses a machine-check output. The low byte of the address register also steers a debug readback of four copyback data words and the copyback address.

Top module: `dcache_ctl_unit`

## Requirements
- R1: Command code 4'b0010 sets the enable bit (status bit 0) and code 4'b0100 clears it, both visible one cycle after the command write, and neither touches the error bits.
- R2: After reset the status port reads 0 (disabled, idle, no errors), the stall output is low and the machine-check output is low.
- R3: With the cache disabled, an idle CPU request asserts the uncached output and never the hit output. Line state is kept, so after re-enabling, a line filled earlier hits again.
- R4: Load-and-lock (code 4'b0110) on a miss issues a memory read of the address register's line and leaves the line valid and locked. On a hit it locks the line with no memory request.
- R5: A locked way is never chosen as a victim on a CPU miss or a lock miss. A CPU miss to a set whose two ways are both locked is served uncached and starts no fill.
- R6: Invalidate-all (4'b1100) drops every unlocked line and keeps every locked line. Unlock-line (4'b1000) clears the lock of the line hit by the address register, and unlock-all (4'b1010) clears every lock.
- R7: Load-and-lock that misses in a set with both ways locked sets the second error bit (status bit 3) at once and issues no memory request.
- R8: A memory error reply during load-and-lock or flush sets the first error bit (status bit 2), clears the enable bit and drives the machine-check output high for exactly one cycle.
- R9: Error bits are set only by load-and-lock and flush, so a failed CPU fill leaves them at 0. They stay set until a status read. A status read in the same cycle that an error is set leaves the bit at 1.
- R10: While a command or fill runs, busy (status bit 1) and the stall output are high, the CPU is not served, the memory request and address stay steady until acknowledged, and a command written meanwhile is ignored.
- R11: Flush (4'b1110) on a hit issues a memory write (mem_we_o = 1) of the line and, on a good reply, invalidates it. Flush on a miss finishes at once with no memory request.
- R12: The debug readback returns copyback word k for address-register low byte k (k = 0 to 3), the copyback address for 8'h04, and 0 for any other value.
- R13: When a command write and a CPU request arrive in the same idle cycle, the command is executed and the CPU request is neither hit nor served uncached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_code_i | input | 4 | Command code |
| adr_wr_i | input | 1 | Address register write strobe |
| adr_data_i | input | ADDR_W | Address register write data |
| stat_rd_i | input | 1 | Status read strobe, clears error bits |
| stat_o | output | 4 | {err2, err1, busy, enable} |
| cb_words_i | input | 4*CB_W | Copyback buffer data words, word 0 in the low bits |
| cb_addr_i | input | CB_W | Copyback buffer address |
| dbg_rdata_o | output | CB_W | Debug readback data |
| cpu_req_i | input | 1 | CPU access request |
| cpu_line_i | input | ADDR_W-OFF_W | CPU line address |
| cpu_hit_o | output | 1 | Request hit in the cache |
| cpu_uncached_o | output | 1 | Request served as an uncached single-beat transfer |
| cpu_stall_o | output | 1 | CPU must hold its request |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Transfer is a write-back |
| mem_addr_o | output | ADDR_W | Line-aligned transfer address |
| mem_ack_i | input | 1 | Transfer completion |
| mem_err_i | input | 1 | Transfer failed, valid with mem_ack_i |
| mchk_o | output | 1 | Machine-check pulse |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a failing memory reply that sets an error bit and a status read that clears it. The bench raises mem_ack_i, mem_err_i and stat_rd_i on the same edge during a lock refill, and the first error bit must still read 1 afterwards. The second pair is a command write and a CPU request in one idle cycle. The bench drives both with the cache disabled, so an uncached response would be visible, and it expects neither hit nor uncached in that cycle and the enable taking effect on the next.

// File: rtl/dcache_ctl_pkg.sv
package dcache_ctl_pkg;
  localparam int unsigned NUM_WAYS     = 2;
  localparam int unsigned NUM_CB_WORDS = 4;

  typedef enum logic [3:0] {
    CMD_ENABLE      = 4'b0010,
    CMD_DISABLE     = 4'b0100,
    CMD_LOCK        = 4'b0110,
    CMD_UNLOCK_LINE = 4'b1000,
    CMD_UNLOCK_ALL  = 4'b1010,
    CMD_INVAL_ALL   = 4'b1100,
    CMD_FLUSH       = 4'b1110
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOCK_FILL,
    ST_CPU_FILL,
    ST_FLUSH
  } state_e;
endpackage

// File: rtl/dcache_tag_array.sv
module dcache_tag_array
  import dcache_ctl_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 24,
  parameter int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    lk_idx_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  output logic [NUM_WAYS-1:0] hit_o,
  output logic [NUM_WAYS-1:0] valid_o,
  output logic [NUM_WAYS-1:0] lock_o,
  output logic                rr_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                wr_way_i,
  input  logic                wr_valid_i,
  input  logic                wr_lock_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  logic                wr_rr_i,
  input  logic                inval_unlocked_i,
  input  logic                clr_locks_i
);
  logic [NUM_WAYS-1:0] valid_q [SETS];
  logic [NUM_WAYS-1:0] lock_q  [SETS];
  logic [TAG_W-1:0]    tag_q   [SETS][NUM_WAYS];
  logic [SETS-1:0]     rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lock_q[s]  <= '0;
        for (int w = 0; w < NUM_WAYS; w++) tag_q[s][w] <= '0;
      end
      rr_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (inval_unlocked_i) valid_q[s] <= valid_q[s] & lock_q[s];
        if (clr_locks_i)      lock_q[s]  <= '0;
      end
      if (wr_en_i) begin
        valid_q[wr_idx_i][wr_way_i] <= wr_valid_i;
        lock_q[wr_idx_i][wr_way_i]  <= wr_lock_i;
        tag_q[wr_idx_i][wr_way_i]   <= wr_tag_i;
        if (wr_rr_i) rr_q[wr_idx_i] <= ~wr_way_i;
      end
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_o[w] = valid_q[lk_idx_i][w] && (tag_q[lk_idx_i][w] == lk_tag_i);
  end

  assign valid_o = valid_q[lk_idx_i];
  assign lock_o  = lock_q[lk_idx_i];
  assign rr_o    = rr_q[lk_idx_i];
endmodule

// File: rtl/dcache_victim_sel.sv
module dcache_victim_sel
  import dcache_ctl_pkg::*;
(
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [NUM_WAYS-1:0] lock_i,
  input  logic                rr_i,
  output logic                way_o,
  output logic                full_o
);
  // locked ways are never victims; empty ways are preferred over round-robin
  always_comb begin
    full_o = &lock_i;
    if (lock_i[0])       way_o = 1'b1;
    else if (lock_i[1])  way_o = 1'b0;
    else if (!valid_i[0]) way_o = 1'b0;
    else if (!valid_i[1]) way_o = 1'b1;
    else                 way_o = rr_i;
  end
endmodule

// File: rtl/dcache_cb_readback.sv
module dcache_cb_readback
  import dcache_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 8
) (
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [NUM_CB_WORDS*DATA_W-1:0] words_i,
  input  logic [DATA_W-1:0]              addr_i,
  output logic [DATA_W-1:0]              rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CB_WORDS; k++) begin
      if (sel_i == SEL_W'(k)) rdata_o = words_i[k*DATA_W +: DATA_W];
    end
    if (sel_i == SEL_W'(NUM_CB_WORDS)) rdata_o = addr_i;
  end
endmodule

// File: rtl/dcache_ctl_unit.sv
module dcache_ctl_unit
  import dcache_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SETS       = 16,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned CB_W       = 32,
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_wr_i,
  input  logic [3:0]                   cmd_code_i,
  input  logic                         adr_wr_i,
  input  logic [ADDR_W-1:0]            adr_data_i,
  input  logic                         stat_rd_i,
  output logic [3:0]                   stat_o,
  input  logic [NUM_CB_WORDS*CB_W-1:0] cb_words_i,
  input  logic [CB_W-1:0]              cb_addr_i,
  output logic [CB_W-1:0]              dbg_rdata_o,
  input  logic                         cpu_req_i,
  input  logic [ADDR_W-OFF_W-1:0]      cpu_line_i,
  output logic                         cpu_hit_o,
  output logic                         cpu_uncached_o,
  output logic                         cpu_stall_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  input  logic                         mem_ack_i,
  input  logic                         mem_err_i,
  output logic                         mchk_o
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;

  state_e             state_q;
  logic               en_q, err1_q, err2_q, mchk_q;
  logic [ADDR_W-1:0]  adr_q;
  logic [IDX_W-1:0]   tgt_idx_q;
  logic [TAG_W-1:0]   tgt_tag_q;
  logic               tgt_way_q;

  cmd_e               cmd;
  logic               busy, cmd_go, cpu_go, cpu_fill, xfer_done;
  logic [IDX_W-1:0]   lk_idx;
  logic [TAG_W-1:0]   lk_tag;
  logic [NUM_WAYS-1:0] hit, way_valid, way_lock;
  logic               rr, hit_any, hit_way, vic_way, set_full;

  logic               wr_en, wr_way, wr_valid, wr_lock, wr_rr;
  logic [IDX_W-1:0]   wr_idx;
  logic [TAG_W-1:0]   wr_tag;
  logic               inval_unlocked, clr_locks;

  assign cmd       = cmd_e'(cmd_code_i);
  assign busy      = (state_q != ST_IDLE);
  assign cmd_go    = cmd_wr_i && !busy;
  assign xfer_done = busy && mem_ack_i;

  // command lookups use the address register, otherwise the CPU line
  assign lk_idx = cmd_wr_i ? adr_q[OFF_W +: IDX_W] : cpu_line_i[IDX_W-1:0];
  assign lk_tag = cmd_wr_i ? adr_q[ADDR_W-1 -: TAG_W] : cpu_line_i[ADDR_W-OFF_W-1 -: TAG_W];

  dcache_tag_array #(
    .SETS (SETS),
    .TAG_W(TAG_W),
    .IDX_W(IDX_W)
  ) u_tags (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .lk_idx_i        (lk_idx),
    .lk_tag_i        (lk_tag),
    .hit_o           (hit),
    .valid_o         (way_valid),
    .lock_o          (way_lock),
    .rr_o            (rr),
    .wr_en_i         (wr_en),
    .wr_idx_i        (wr_idx),
    .wr_way_i        (wr_way),
    .wr_valid_i      (wr_valid),
    .wr_lock_i       (wr_lock),
    .wr_tag_i        (wr_tag),
    .wr_rr_i         (wr_rr),
    .inval_unlocked_i(inval_unlocked),
    .clr_locks_i     (clr_locks)
  );

  dcache_victim_sel u_victim (
    .valid_i(way_valid),
    .lock_i (way_lock),
    .rr_i   (rr),
    .way_o  (vic_way),
    .full_o (set_full)
  );

  dcache_cb_readback #(
    .DATA_W(CB_W),
    .SEL_W (SEL_W)
  ) u_readback (
    .sel_i  (adr_q[SEL_W-1:0]),
    .words_i(cb_words_i),
    .addr_i (cb_addr_i),
    .rdata_o(dbg_rdata_o)
  );

  assign hit_any  = |hit;
  assign hit_way  = ~hit[0];

  // a command written in the same cycle takes priority over the CPU
  assign cpu_go         = cpu_req_i && !busy && !cmd_wr_i;
  assign cpu_hit_o      = cpu_go && en_q && hit_any;
  assign cpu_uncached_o = cpu_go && (!en_q || (!hit_any && set_full));
  assign cpu_fill       = cpu_go && en_q && !hit_any && !set_full;
  assign cpu_stall_o    = busy;

  assign inval_unlocked = cmd_go && (cmd == CMD_INVAL_ALL);
  assign clr_locks      = cmd_go && (cmd == CMD_UNLOCK_ALL);

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = lk_idx;
    wr_way   = hit_way;
    wr_valid = 1'b1;
    wr_lock  = 1'b0;
    wr_tag   = lk_tag;
    wr_rr    = 1'b0;
    if (cmd_go) begin
      if (cmd == CMD_LOCK && hit_any) begin
        wr_en   = 1'b1;
        wr_lock = 1'b1;
      end else if (cmd == CMD_UNLOCK_LINE && hit_any) begin
        wr_en   = 1'b1;
      end
    end else if (xfer_done) begin
      wr_idx = tgt_idx_q;
      wr_way = tgt_way_q;
      wr_tag = tgt_tag_q;
      if (state_q == ST_FLUSH) begin
        wr_en    = !mem_err_i;
        wr_valid = 1'b0;
      end else begin
        wr_en    = 1'b1;
        wr_valid = !mem_err_i;
        wr_lock  = (state_q == ST_LOCK_FILL) && !mem_err_i;
        wr_rr    = !mem_err_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q <= '0;
    end else if (adr_wr_i) begin
      adr_q <= adr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      en_q      <= 1'b0;
      err1_q    <= 1'b0;
      err2_q    <= 1'b0;
      mchk_q    <= 1'b0;
      tgt_idx_q <= '0;
      tgt_tag_q <= '0;
      tgt_way_q <= 1'b0;
    end else begin
      mchk_q <= 1'b0;
      // clear-on-read comes first so a same-cycle set wins
      if (stat_rd_i) begin
        err1_q <= 1'b0;
        err2_q <= 1'b0;
      end
      if (cmd_go) begin
        case (cmd)
          CMD_ENABLE:  en_q <= 1'b1;
          CMD_DISABLE: en_q <= 1'b0;
          CMD_LOCK: begin
            if (!hit_any) begin
              if (set_full) begin
                err2_q <= 1'b1;
              end else begin
                state_q   <= ST_LOCK_FILL;
                tgt_idx_q <= lk_idx;
                tgt_tag_q <= lk_tag;
                tgt_way_q <= vic_way;
              end
            end
          end
          CMD_FLUSH: begin
            if (hit_any) begin
              state_q   <= ST_FLUSH;
              tgt_idx_q <= lk_idx;
              tgt_tag_q <= lk_tag;
              tgt_way_q <= hit_way;
            end
          end
          default: ;
        endcase
      end else if (cpu_fill) begin
        state_q   <= ST_CPU_FILL;
        tgt_idx_q <= lk_idx;
        tgt_tag_q <= lk_tag;
        tgt_way_q <= vic_way;
      end else if (xfer_done) begin
        state_q <= ST_IDLE;
        if (mem_err_i && state_q != ST_CPU_FILL) begin
          err1_q <= 1'b1;
          en_q   <= 1'b0;
          mchk_q <= 1'b1;
        end
      end
    end
  end

  assign stat_o     = {err2_q, err1_q, busy, en_q};
  assign mem_req_o  = busy;
  assign mem_we_o   = (state_q == ST_FLUSH);
  assign mem_addr_o = {tgt_tag_q, tgt_idx_q, {OFF_W{1'b0}}};
  assign mchk_o     = mchk_q;
endmodule

// File: rtl/dcache_ctl_chk.sv
module dcache_ctl_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic [3:0]        cmd_code_i,
  input logic [3:0]        stat_o,
  input logic              cpu_req_i,
  input logic              cpu_hit_o,
  input logic              cpu_uncached_o,
  input logic              cpu_stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              mem_err_i,
  input logic              mchk_o
);
  AST_ENABLE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !stat_o[1] && cmd_code_i == 4'b0010 |=> stat_o[0]);  // R1
  AST_DISABLE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !stat_o[1] && cmd_code_i == 4'b0100 |=> !stat_o[0]);  // R1
  AST_OFF_UNCACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !stat_o[0] && !cpu_stall_o && !cmd_wr_i |-> cpu_uncached_o && !cpu_hit_o);  // R3
  AST_MCHK_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_o |-> !stat_o[0] && stat_o[2]);  // R8
  AST_MCHK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_o |=> !mchk_o);  // R8
  AST_ERR1_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[2]) |-> $past(mem_req_o && mem_ack_i && mem_err_i));  // R9
  AST_BUSY_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[1] |-> cpu_stall_o && !cpu_hit_o && !cpu_uncached_o);  // R10
  AST_REQ_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));  // R10
  AST_WRITE_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);  // R11
  AST_CMD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |-> !cpu_hit_o && !cpu_uncached_o);  // R13
endmodule

bind dcache_ctl_unit dcache_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_wr_i      (cmd_wr_i),
  .cmd_code_i    (cmd_code_i),
  .stat_o        (stat_o),
  .cpu_req_i     (cpu_req_i),
  .cpu_hit_o     (cpu_hit_o),
  .cpu_uncached_o(cpu_uncached_o),
  .cpu_stall_o   (cpu_stall_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_ack_i     (mem_ack_i),
  .mem_err_i     (mem_err_i),
  .mchk_o        (mchk_o)
);

// File: tb/dcache_ctl_unit_tb.sv
module dcache_ctl_unit_tb;
  localparam logic [3:0] C_EN = 4'b0010, C_DIS = 4'b0100, C_LOCK = 4'b0110,
                         C_UNL = 4'b1000, C_UNLA = 4'b1010, C_INV = 4'b1100,
                         C_FLUSH = 4'b1110;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_wr_i = 1'b0;
  logic [3:0]  cmd_code_i = '0;
  logic        adr_wr_i = 1'b0;
  logic [31:0] adr_data_i = '0;
  logic        stat_rd_i = 1'b0;
  logic [3:0]  stat_o;
  logic [127:0] cb_words_i = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
  logic [31:0] cb_addr_i = 32'h1234_5670;
  logic [31:0] dbg_rdata_o;
  logic        cpu_req_i = 1'b0;
  logic [27:0] cpu_line_i = '0;
  logic        cpu_hit_o, cpu_uncached_o, cpu_stall_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic        mem_err_i = 1'b0;
  logic        mchk_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dcache_ctl_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr_i), .cmd_code_i(cmd_code_i),
    .adr_wr_i(adr_wr_i), .adr_data_i(adr_data_i), .stat_rd_i(stat_rd_i), .stat_o(stat_o),
    .cb_words_i(cb_words_i), .cb_addr_i(cb_addr_i), .dbg_rdata_o(dbg_rdata_o),
    .cpu_req_i(cpu_req_i), .cpu_line_i(cpu_line_i), .cpu_hit_o(cpu_hit_o),
    .cpu_uncached_o(cpu_uncached_o), .cpu_stall_o(cpu_stall_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_err_i(mem_err_i), .mchk_o(mchk_o)
  );

  function automatic logic [27:0] ln(input logic [23:0] t, input logic [3:0] i);
    return {t, i};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] c);
    @(negedge clk); cmd_wr_i = 1'b1; cmd_code_i = c;
    @(negedge clk); cmd_wr_i = 1'b0;
  endtask

  task automatic set_adr(input logic [31:0] a);
    @(negedge clk); adr_wr_i = 1'b1; adr_data_i = a;
    @(negedge clk); adr_wr_i = 1'b0;
  endtask

  task automatic rd_stat(output logic [3:0] v);
    @(negedge clk); stat_rd_i = 1'b1; v = stat_o;
    @(negedge clk); stat_rd_i = 1'b0;
  endtask

  task automatic mem_reply(input logic err);
    int n = 0;
    while (!mem_req_o && n < 50) begin @(negedge clk); n++; end
    mem_ack_i = 1'b1; mem_err_i = err;
    @(negedge clk); mem_ack_i = 1'b0; mem_err_i = 1'b0;
  endtask

  task automatic cpu_acc(input logic [27:0] l, input logic err, output logic h, output logic u);
    @(negedge clk); cpu_req_i = 1'b1; cpu_line_i = l;
    #1; h = cpu_hit_o; u = cpu_uncached_o;
    @(negedge clk); cpu_req_i = 1'b0;
    if (cpu_stall_o) mem_reply(err);
  endtask

  task automatic t_reset;
    check("R2 status", stat_o, 4'b0000);
    check("R2 stall", cpu_stall_o, 1'b0);
    check("R2 mchk", mchk_o, 1'b0);
  endtask

  task automatic t_enable_fill;
    logic h, u;
    cpu_acc(ln(1, 3), 1'b0, h, u);
    check("R3 off uncached", {h, u}, 2'b01);
    check("R3 off no stall", cpu_stall_o, 1'b0);
    cmd(C_EN);
    check("R1 enable", stat_o, 4'b0001);
    @(negedge clk); cpu_req_i = 1'b1; cpu_line_i = ln(1, 3);
    #1; check("R5 miss", {cpu_hit_o, cpu_uncached_o}, 2'b00);
    @(negedge clk); cpu_req_i = 1'b0;
    check("R10 stall", {cpu_stall_o, stat_o[1]}, 2'b11);
    check("R10 fill req", {mem_req_o, mem_we_o, mem_addr_o}, {1'b1, 1'b0, ln(1, 3), 4'h0});
    mem_reply(1'b0);
    cpu_acc(ln(1, 3), 1'b0, h, u);
    check("R5 filled hit", {h, u}, 2'b10);
  endtask

  task automatic t_retain;
    logic h, u;
    cmd(C_DIS);
    check("R1 disable", stat_o, 4'b0000);
    cpu_acc(ln(1, 3), 1'b0, h, u);
    check("R3 off ignores hit", {h, u}, 2'b01);
    cmd(C_EN);
    cpu_acc(ln(1, 3), 1'b0, h, u);
    check("R3 state kept", {h, u}, 2'b10);
  endtask

  task automatic t_lock;
    logic h, u;
    set_adr({ln(2, 5), 4'h0});
    cmd(C_LOCK);
    check("R4 lock busy", stat_o, 4'b0011);
    check("R4 lock read", {mem_req_o, mem_we_o, mem_addr_o}, {1'b1, 1'b0, ln(2, 5), 4'h0});
    cmd(C_DIS);
    check("R10 cmd ignored", stat_o, 4'b0011);
    mem_reply(1'b0);
    check("R4 lock done", stat_o, 4'b0001);
    cpu_acc(ln(2, 5), 1'b0, h, u);
    check("R4 locked hit", {h, u}, 2'b10);
    set_adr({ln(1, 3), 4'h0});
    cmd(C_LOCK);
    check("R4 lock hit no fetch", {stat_o, mem_req_o}, {4'b0001, 1'b0});
  endtask

  task automatic t_victim;
    logic h, u;
    cpu_acc(ln(3, 5), 1'b0, h, u);
    check("R5 C miss", h, 1'b0);
    cpu_acc(ln(4, 5), 1'b0, h, u);
    check("R5 D miss", h, 1'b0);
    cpu_acc(ln(2, 5), 1'b0, h, u);
    check("R5 locked kept", {h, u}, 2'b10);
    cpu_acc(ln(4, 5), 1'b0, h, u);
    check("R5 D hit", h, 1'b1);
    cpu_acc(ln(3, 5), 1'b0, h, u);
    check("R5 C evicted", h, 1'b0);
    set_adr({ln(5, 5), 4'h0});
    cmd(C_LOCK);
    mem_reply(1'b0);
    cpu_acc(ln(2, 5), 1'b0, h, u);
    check("R5 B still locked", h, 1'b1);
    cpu_acc(ln(6, 5), 1'b0, h, u);
    check("R5 full set uncached", {h, u, cpu_stall_o}, 3'b010);
  endtask

  task automatic t_err2;
    logic [3:0] v;
    set_adr({ln(7, 5), 4'h0});
    cmd(C_LOCK);
    check("R7 err2 set", {stat_o, mem_req_o}, {4'b1001, 1'b0});
    @(negedge clk);
    check("R9 err2 sticky", stat_o, 4'b1001);
    rd_stat(v);
    check("R9 read value", v, 4'b1001);
    check("R9 cleared", stat_o, 4'b0001);
  endtask

  task automatic t_inval;
    logic h, u;
    cpu_acc(ln(8, 7), 1'b0, h, u);
    cmd(C_INV);
    cpu_acc(ln(8, 7), 1'b0, h, u);
    check("R6 unlocked dropped", h, 1'b0);
    cpu_acc(ln(1, 3), 1'b0, h, u);
    check("R6 locked A kept", h, 1'b1);
    cpu_acc(ln(2, 5), 1'b0, h, u);
    check("R6 locked B kept", h, 1'b1);
    set_adr({ln(2, 5), 4'h0});
    cmd(C_UNL);
    cmd(C_INV);
    cpu_acc(ln(2, 5), 1'b0, h, u);
    check("R6 unlock line", h, 1'b0);
    cpu_acc(ln(5, 5), 1'b0, h, u);
    check("R6 E kept", h, 1'b1);
    cmd(C_UNLA);
    cmd(C_INV);
    cpu_acc(ln(5, 5), 1'b0, h, u);
    check("R6 unlock all E", h, 1'b0);
    cpu_acc(ln(1, 3), 1'b0, h, u);
    check("R6 unlock all A", h, 1'b0);
    check("R9 no error", stat_o, 4'b0001);
  endtask

  task automatic t_flush;
    logic h, u;
    cpu_acc(ln(9, 9), 1'b0, h, u);
    set_adr({ln(9, 9), 4'h0});
    cmd(C_FLUSH);
    check("R11 write back", {stat_o[1], mem_req_o, mem_we_o, mem_addr_o}, {3'b111, ln(9, 9), 4'h0});
    mem_reply(1'b0);
    cpu_acc(ln(9, 9), 1'b0, h, u);
    check("R11 invalidated", h, 1'b0);
    set_adr({ln(10, 9), 4'h0});
    cmd(C_FLUSH);
    check("R11 miss no-op", {stat_o, mem_req_o}, {4'b0001, 1'b0});
  endtask

  task automatic t_flush_err;
    logic [3:0] v;
    set_adr({ln(9, 9), 4'h0});
    cmd(C_FLUSH);
    @(negedge clk); mem_ack_i = 1'b1; mem_err_i = 1'b1;
    @(negedge clk); mem_ack_i = 1'b0; mem_err_i = 1'b0;
    check("R8 mchk and disable", {mchk_o, stat_o}, {1'b1, 4'b0100});
    @(negedge clk);
    check("R8 mchk one cycle", mchk_o, 1'b0);
    rd_stat(v);
    check("R9 err1 read", v, 4'b0100);
    cmd(C_EN);
  endtask

  task automatic t_fill_err;
    logic h, u;
    cpu_acc(ln(11, 12), 1'b1, h, u);
    check("R9 cpu fill error ignored", {stat_o, mchk_o}, {4'b0001, 1'b0});
  endtask

  task automatic t_set_vs_clear;
    logic [3:0] v;
    set_adr({ln(12, 13), 4'h0});
    cmd(C_LOCK);
    @(negedge clk); mem_ack_i = 1'b1; mem_err_i = 1'b1; stat_rd_i = 1'b1;
    @(negedge clk); mem_ack_i = 1'b0; mem_err_i = 1'b0; stat_rd_i = 1'b0;
    check("R9 set beats clear", stat_o, 4'b0100);
    rd_stat(v);
    check("R9 later clear", stat_o, 4'b0000);
    cmd(C_EN);
  endtask

  task automatic t_readback;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] exp;
      set_adr({24'h0, 8'(k)});
      case (k)
        0: exp = 32'hAAAA0000;
        1: exp = 32'hBBBB0001;
        2: exp = 32'hCCCC0002;
        3: exp = 32'hDDDD0003;
        4: exp = 32'h12345670;
        default: exp = 32'h0;
      endcase
      check("R12 readback", dbg_rdata_o, exp);
    end
  endtask

  task automatic t_cmd_wins;
    cmd(C_DIS);
    @(negedge clk); cpu_req_i = 1'b1; cpu_line_i = ln(1, 3); cmd_wr_i = 1'b1; cmd_code_i = C_EN;
    #1; check("R13 cpu not served", {cpu_hit_o, cpu_uncached_o}, 2'b00);
    @(negedge clk); cpu_req_i = 1'b0; cmd_wr_i = 1'b0;
    check("R13 command done", stat_o, 4'b0001);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_fill();
    t_retain();
    t_lock();
    t_victim();
    t_err2();
    t_inval();
    t_flush();
    t_flush_err();
    t_fill_err();
    t_set_vs_clear();
    t_readback();
    t_cmd_wins();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule